// File: doc/BRIEF.md
# Complementary PWM Motor Timer

This block is a 16-bit timer for driving motor half-bridges. One counter runs up or down over a period set by a reload value. Four compare channels turn that count into PWM. Each channel drives a high-side output and a low-side output. A dead-time gap delays the rising edge of either output, so a bridge leg never conducts on both sides at once.

A repetition count thins out update events. Only every (N+1)-th period end produces one. Each update event moves the shadowed reload and compare values into the live registers and pulses an output that other logic can use as a trigger. A brake input forces every output to a programmed idle level in the same cycle, with no clock edge needed. A sticky flag keeps the outputs idle until software releases it.

Software reaches the block through a single-cycle register bus. The bus has a write strobe, an address and write data. Read data is combinational and follows the address.

Top module: `mtr_pwm_timer`

## Requirements
- R1: When running in up mode, the counter steps 0,1,…,reload and then returns to 0. In down mode it steps from reload to 0 and then reloads. Either way a period lasts reload+1 clocks. While the run bit is 0 the counter is held at 0. The counter reads back at address 10.
- R2: A period end is the clock where the count is at reload (up mode) or at 0 (down mode). With a repeat value N, only every (N+1)-th period end is an update event. `updPulse` is high for exactly that one clock.
- R3: Writes to reload (address 1) and to compares (addresses 4 to 7, channel 0 first) go to shadow copies. They reach the live registers only at an update event. While the run bit is 0 they are copied through every clock.
- R4: The internal reference of each channel is high while the counter is below the live compare value of that channel. The outputs follow the reference one clock after the counter value. A compare of 0 keeps the reference low, and a compare above reload keeps it high.
- R5: The dead time (address 3, 8 bits, in clocks) works as follows. When a reference changes, the output that is falling drops on the next clock. The output that is rising goes high only after a further dead-time number of clocks.
- R6: While running with no brake active, `pwmHi[i]` and `pwmLo[i]` are never high together.
- R7: While `brakeIn` is high, all outputs take their idle levels in the same cycle. Idle levels are set at address 8: bits [3:0] for `pwmHi` and bits [7:4] for `pwmLo`. The brake also sets brake flag status bit 0 at the next clock.
- R8: Writing status (address 9) with bit 0 set clears the brake flag, but only when `brakeIn` is low in that cycle. While the flag is set, the outputs stay at their idle levels.
- R9: While the run bit (address 0, bit 0) is 0, the outputs sit at their idle levels. Address 0, bit 1 selects down counting.
- R10: Status bit 1 is set by every update event. Writing status with bit 1 set clears it. An update event in the same cycle wins over the clear.
- R11: Reset clears every register to 0, so all outputs start low. Addresses 0 to 8 read back their written values: run/direction, reload, repeat in bits [7:0], dead time, compares and idle levels. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 4 | Register address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for busAddr |
| brakeIn | input | 1 | Brake request, active high |
| pwmHi | output | 4 | High-side output per channel |
| pwmLo | output | 4 | Low-side output per channel |
| updPulse | output | 1 | One-clock update event strobe |

## Verification
Several things can land on one clock edge: a brake edge and an update event, a status clear and a new brake or update, or a shadow write and the period end that commits it. Fixed-seed random stimulus writes short reloads, random compares, small repeat and dead-time values, and brake pulses and status clears at random times. This makes such overlaps common. Directed phases add a clear attempt while the brake is still held, and compares at 0 and above reload. On every clock a cycle-level bench model built from the requirements predicts the outputs, the update strobe and the addressed read data, and the bench compares the design against it.

// File: rtl/mtr_pwm_pkg.sv
package mtr_pwm_pkg;
  // fixed register offsets; per-channel and trailing registers derive from the channel count
  localparam int REG_CTRL   = 0;
  localparam int REG_RELOAD = 1;
  localparam int REG_REPEAT = 2;
  localparam int REG_DEAD   = 3;
  localparam int REG_CMP0   = 4;

  // control-to-datapath strobes
  typedef struct packed {
    logic run;
    logic down;
  } tmrCtl_t;
endpackage

// File: rtl/mtr_pwm_ctrl.sv
module mtr_pwm_ctrl
  import mtr_pwm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int RW  = 8,
  parameter int DW  = 8,
  parameter int AW  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    busWe,
  input  logic [AW-1:0]           busAddr,
  input  logic [CW-1:0]           busWdata,
  output logic [CW-1:0]           busRdata,
  input  logic                    brakeIn,
  input  logic                    updEvt,
  input  logic [CW-1:0]           cntVal,
  output tmrCtl_t                 ctl,
  output logic [CW-1:0]           reloadSh,
  output logic [RW-1:0]           repSh,
  output logic [DW-1:0]           deadT,
  output logic [NCH-1:0][CW-1:0]  cmpSh,
  output logic [2*NCH-1:0]        idleLv,
  output logic                    brakeFlag
);
  localparam int REG_IDLE  = REG_CMP0 + NCH;
  localparam int REG_STAT  = REG_IDLE + 1;
  localparam int REG_COUNT = REG_STAT + 1;

  logic updFlag;
  logic statWr;

  assign statWr = busWe && (busAddr == AW'(REG_STAT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctl      <= '0;
      reloadSh <= '0;
      repSh    <= '0;
      deadT    <= '0;
      cmpSh    <= '0;
      idleLv   <= '0;
    end else if (busWe) begin
      if (busAddr == AW'(REG_CTRL)) begin
        ctl.run  <= busWdata[0];
        ctl.down <= busWdata[1];
      end
      if (busAddr == AW'(REG_RELOAD)) reloadSh <= busWdata;
      if (busAddr == AW'(REG_REPEAT)) repSh    <= busWdata[RW-1:0];
      if (busAddr == AW'(REG_DEAD))   deadT    <= busWdata[DW-1:0];
      if (busAddr == AW'(REG_IDLE))   idleLv   <= busWdata[2*NCH-1:0];
      for (int i = 0; i < NCH; i++) begin
        if (busAddr == AW'(REG_CMP0 + i)) cmpSh[i] <= busWdata;
      end
    end
  end

  // sticky flags: a new set event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brakeFlag <= 1'b0;
      updFlag   <= 1'b0;
    end else begin
      if (brakeIn)                     brakeFlag <= 1'b1;
      else if (statWr && busWdata[0])  brakeFlag <= 1'b0;
      if (updEvt)                      updFlag   <= 1'b1;
      else if (statWr && busWdata[1])  updFlag   <= 1'b0;
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == AW'(REG_CTRL))   busRdata = CW'({ctl.down, ctl.run});
    if (busAddr == AW'(REG_RELOAD)) busRdata = reloadSh;
    if (busAddr == AW'(REG_REPEAT)) busRdata = CW'(repSh);
    if (busAddr == AW'(REG_DEAD))   busRdata = CW'(deadT);
    if (busAddr == AW'(REG_IDLE))   busRdata = CW'(idleLv);
    if (busAddr == AW'(REG_STAT))   busRdata = CW'({updFlag, brakeFlag});
    if (busAddr == AW'(REG_COUNT))  busRdata = cntVal;
    for (int i = 0; i < NCH; i++) begin
      if (busAddr == AW'(REG_CMP0 + i)) busRdata = cmpSh[i];
    end
  end

  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    brakeIn |=> brakeFlag);

  p_upd_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    updEvt |=> updFlag);
endmodule

// File: rtl/mtr_pwm_dpath.sv
module mtr_pwm_dpath
  import mtr_pwm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int RW  = 8,
  parameter int DW  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  tmrCtl_t                 ctl,
  input  logic [CW-1:0]           reloadSh,
  input  logic [RW-1:0]           repSh,
  input  logic [DW-1:0]           deadT,
  input  logic [NCH-1:0][CW-1:0]  cmpSh,
  output logic [CW-1:0]           cntVal,
  output logic                    updEvt,
  output logic [NCH-1:0]          hiPwm,
  output logic [NCH-1:0]          loPwm
);
  logic [CW-1:0]          reloadAct;
  logic [NCH-1:0][CW-1:0] cmpAct;
  logic [RW-1:0]          repLeft;
  logic                   periodEnd;
  logic [CW-1:0]          nextBase;

  assign periodEnd = ctl.down ? (cntVal == '0) : (cntVal == reloadAct);
  assign updEvt    = ctl.run && periodEnd && (repLeft == '0);
  assign nextBase  = updEvt ? reloadSh : reloadAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal    <= '0;
      reloadAct <= '0;
      cmpAct    <= '0;
      repLeft   <= '0;
    end else if (!ctl.run) begin
      cntVal    <= '0;
      reloadAct <= reloadSh;
      cmpAct    <= cmpSh;
      repLeft   <= repSh;
    end else begin
      if (periodEnd) cntVal <= ctl.down ? nextBase : '0;
      else           cntVal <= ctl.down ? cntVal - 1'b1 : cntVal + 1'b1;
      if (updEvt) begin
        reloadAct <= reloadSh;
        cmpAct    <= cmpSh;
        repLeft   <= repSh;
      end else if (periodEnd) begin
        repLeft   <= repLeft - 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic          refNow;
    logic          refQ;
    logic [DW-1:0] age;

    assign refNow = cntVal < cmpAct[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        refQ <= 1'b0;
        age  <= '0;
      end else begin
        refQ <= refNow;
        if (refNow != refQ)  age <= '0;
        else if (age != '1)  age <= age + 1'b1;
      end
    end

    assign hiPwm[g] = refQ  && (age >= deadT);
    assign loPwm[g] = !refQ && (age >= deadT);

    p_dead_gap_r5: assert property (@(posedge clk) disable iff (!rstN)
      ((deadT != '0) && $rose(hiPwm[g])) |-> ($past(loPwm[g]) == 1'b0));
  end

  p_wrap_up_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.run && !ctl.down && (cntVal == reloadAct)) |=> (cntVal == '0));

  p_rep_reload_r2: assert property (@(posedge clk) disable iff (!rstN)
    updEvt |=> (repLeft == $past(repSh)));

  p_shadow_commit_r3: assert property (@(posedge clk) disable iff (!rstN)
    updEvt |=> (reloadAct == $past(reloadSh)));
endmodule

// File: rtl/mtr_pwm_timer.sv
module mtr_pwm_timer
  import mtr_pwm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int RW  = 8,
  parameter int DW  = 8,
  parameter int AW  = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            busWe,
  input  logic [AW-1:0]   busAddr,
  input  logic [CW-1:0]   busWdata,
  output logic [CW-1:0]   busRdata,
  input  logic            brakeIn,
  output logic [NCH-1:0]  pwmHi,
  output logic [NCH-1:0]  pwmLo,
  output logic            updPulse
);
  tmrCtl_t                ctl;
  logic [CW-1:0]          reloadSh;
  logic [RW-1:0]          repSh;
  logic [DW-1:0]          deadT;
  logic [NCH-1:0][CW-1:0] cmpSh;
  logic [2*NCH-1:0]       idleLv;
  logic                   brakeFlag;
  logic [CW-1:0]          cntVal;
  logic                   updEvt;
  logic [NCH-1:0]         hiPwm;
  logic [NCH-1:0]         loPwm;
  logic                   forceIdle;

  mtr_pwm_ctrl #(.NCH(NCH), .CW(CW), .RW(RW), .DW(DW), .AW(AW)) ctrl_i (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .brakeIn(brakeIn),
    .updEvt(updEvt), .cntVal(cntVal), .ctl(ctl), .reloadSh(reloadSh),
    .repSh(repSh), .deadT(deadT), .cmpSh(cmpSh), .idleLv(idleLv),
    .brakeFlag(brakeFlag)
  );

  mtr_pwm_dpath #(.NCH(NCH), .CW(CW), .RW(RW), .DW(DW)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reloadSh(reloadSh), .repSh(repSh),
    .deadT(deadT), .cmpSh(cmpSh), .cntVal(cntVal), .updEvt(updEvt),
    .hiPwm(hiPwm), .loPwm(loPwm)
  );

  // brake path is combinational from the pin so it acts without a clock edge
  assign forceIdle = brakeIn || brakeFlag || !ctl.run;
  assign pwmHi     = forceIdle ? idleLv[NCH-1:0]     : hiPwm;
  assign pwmLo     = forceIdle ? idleLv[2*NCH-1:NCH] : loPwm;
  assign updPulse  = updEvt;

  p_brake_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    brakeIn |-> ((pwmHi == idleLv[NCH-1:0]) && (pwmLo == idleLv[2*NCH-1:NCH])));

  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.run && !brakeIn && !brakeFlag) |-> ((pwmHi & pwmLo) == '0));
endmodule

// File: tb/mtr_pwm_timer_tb.sv
module mtr_pwm_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        brakeIn = 1'b0;
  logic [3:0]  pwmHi, pwmLo;
  logic        updPulse;

  int nChk = 0;
  int nErr = 0;
  bit done = 1'b0;

  mtr_pwm_timer dut_i (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .brakeIn(brakeIn),
    .pwmHi(pwmHi), .pwmLo(pwmLo), .updPulse(updPulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---- reference model built from the requirements ----
  logic        mRun, mDown, mBf, mUf;
  logic [15:0] mCnt, mRel, mRelA;
  logic [15:0] mCmp [4];
  logic [15:0] mCmpA [4];
  logic [7:0]  mRep, mRepL, mDt, mIdle;
  logic        mRefQ [4];
  logic [7:0]  mAge [4];

  function automatic logic mEnd();
    return mDown ? (mCnt == 16'd0) : (mCnt == mRelA);
  endfunction

  function automatic logic mUpd();
    return mRun && mEnd() && (mRepL == 8'd0);
  endfunction

  function automatic logic mForce();
    return brakeIn || mBf || !mRun;
  endfunction

  function automatic logic [3:0] expHi();
    logic [3:0] v;
    for (int i = 0; i < 4; i++) v[i] = mRefQ[i] && (mAge[i] >= mDt);
    return mForce() ? mIdle[3:0] : v;
  endfunction

  function automatic logic [3:0] expLo();
    logic [3:0] v;
    for (int i = 0; i < 4; i++) v[i] = !mRefQ[i] && (mAge[i] >= mDt);
    return mForce() ? mIdle[7:4] : v;
  endfunction

  function automatic logic [15:0] expRd(input logic [3:0] a);
    case (a)
      4'd0: return {14'd0, mDown, mRun};
      4'd1: return mRel;
      4'd2: return {8'd0, mRep};
      4'd3: return {8'd0, mDt};
      4'd4, 4'd5, 4'd6, 4'd7: return mCmp[a-4];
      4'd8: return {8'd0, mIdle};
      4'd9: return {14'd0, mUf, mBf};
      4'd10: return mCnt;
      default: return 16'd0;
    endcase
  endfunction

  always @(posedge clk) begin : mdl
    logic pe, up, rf;
    if (!rstN) begin
      mRun <= 0; mDown <= 0; mBf <= 0; mUf <= 0;
      mCnt <= 0; mRel <= 0; mRelA <= 0; mRep <= 0; mRepL <= 0; mDt <= 0; mIdle <= 0;
      for (int i = 0; i < 4; i++) begin
        mCmp[i] <= 0; mCmpA[i] <= 0; mRefQ[i] <= 0; mAge[i] <= 0;
      end
    end else begin
      pe = mEnd();
      up = mUpd();
      if (!mRun) begin
        mCnt <= 0; mRepL <= mRep; mRelA <= mRel;
        for (int i = 0; i < 4; i++) mCmpA[i] <= mCmp[i];
      end else begin
        if (pe) mCnt <= mDown ? (up ? mRel : mRelA) : 16'd0;
        else    mCnt <= mDown ? mCnt - 16'd1 : mCnt + 16'd1;
        if (up) begin
          mRelA <= mRel; mRepL <= mRep;
          for (int i = 0; i < 4; i++) mCmpA[i] <= mCmp[i];
        end else if (pe) mRepL <= mRepL - 8'd1;
      end
      for (int i = 0; i < 4; i++) begin
        rf = mCnt < mCmpA[i];
        mRefQ[i] <= rf;
        if (rf != mRefQ[i])       mAge[i] <= 0;
        else if (mAge[i] != 8'hFF) mAge[i] <= mAge[i] + 8'd1;
      end
      if (busWe) begin
        case (busAddr)
          4'd0: begin mRun <= busWdata[0]; mDown <= busWdata[1]; end
          4'd1: mRel <= busWdata;
          4'd2: mRep <= busWdata[7:0];
          4'd3: mDt <= busWdata[7:0];
          4'd4, 4'd5, 4'd6, 4'd7: mCmp[busAddr-4] <= busWdata;
          4'd8: mIdle <= busWdata[7:0];
          default: ;
        endcase
      end
      if (brakeIn) mBf <= 1'b1;
      else if (busWe && busAddr == 4'd9 && busWdata[0]) mBf <= 1'b0;
      if (up) mUf <= 1'b1;
      else if (busWe && busAddr == 4'd9 && busWdata[1]) mUf <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit cmpPending();
    bit p = (mRel != mRelA);
    for (int i = 0; i < 4; i++) p = p || (mCmp[i] != mCmpA[i]);
    return p;
  endfunction

  // continuous comparison away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      string tg;
      if (brakeIn)           tg = "R7";
      else if (mBf)          tg = "R8";
      else if (!mRun)        tg = "R9";
      else if (cmpPending()) tg = "R3";
      else if (mDt != 0)     tg = "R5";
      else                   tg = "R4";
      chk({pwmHi, pwmLo} == {expHi(), expLo()}, tg, {pwmHi, pwmLo}, {expHi(), expLo()});
      if (mRun && !brakeIn && !mBf)
        chk((pwmHi & pwmLo) == 4'd0, "R6", pwmHi & pwmLo, 0);
      chk(updPulse == mUpd(), "R2", updPulse, mUpd());
      if (busAddr == 4'd10)     chk(busRdata == expRd(busAddr), "R1", busRdata, expRd(busAddr));
      else if (busAddr == 4'd9) chk(busRdata == expRd(busAddr), "R10", busRdata, expRd(busAddr));
      else                      chk(busRdata == expRd(busAddr), "R11", busRdata, expRd(busAddr));
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busWe = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nErr++; nChk++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    cyc(3);
    @(negedge clk);
    chk({pwmHi, pwmLo, updPulse} == 9'd0, "R11", {pwmHi, pwmLo, updPulse}, 0);
    chk(busRdata == 16'd0, "R11", busRdata, 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    cyc(2);

    // up counting, dead time 0, compare corners: 0, mid, above reload, at reload
    wr(4'd1, 16'd9);
    wr(4'd4, 16'd0); wr(4'd5, 16'd5); wr(4'd6, 16'd12); wr(4'd7, 16'd9);
    wr(4'd8, 16'h00F0);
    wr(4'd0, 16'd1);
    busAddr = 4'd10; cyc(40);
    // dead time and repetition
    wr(4'd3, 16'd3); wr(4'd2, 16'd2);
    busAddr = 4'd10; cyc(80);
    // shadow change mid-run
    wr(4'd1, 16'd6); wr(4'd5, 16'd2);
    busAddr = 4'd9; cyc(60);
    // down counting
    wr(4'd0, 16'd3); wr(4'd2, 16'd0);
    busAddr = 4'd10; cyc(50);
    // brake with clear attempt while held
    wr(4'd8, 16'h00A5);
    brakeIn = 1'b1; cyc(3);
    wr(4'd9, 16'd1);
    busAddr = 4'd9;
    @(negedge clk);
    chk(busRdata[0] == 1'b1, "R8", busRdata[0], 1);
    @(posedge clk); #1;
    brakeIn = 1'b0; cyc(5);
    @(negedge clk);
    chk({pwmHi, pwmLo} == 8'h5A, "R8", {pwmHi, pwmLo}, 8'h5A);
    @(posedge clk); #1;
    wr(4'd9, 16'd3);
    busAddr = 4'd9;
    @(negedge clk);
    chk(busRdata[0] == 1'b0, "R8", busRdata[0], 0);
    @(posedge clk); #1;
    cyc(30);
    // stop: outputs go idle
    wr(4'd0, 16'd0); cyc(10);

    // constrained random
    for (int k = 0; k < 6000; k++) begin
      int r = $urandom_range(99);
      busWe = 1'b0;
      busAddr = 4'($urandom_range(11));
      if (r < 3)       begin busWe = 1; busAddr = 4'd1; busWdata = 16'($urandom_range(40, 0)); end
      else if (r < 9)  begin busWe = 1; busAddr = 4'(4 + $urandom_range(3)); busWdata = 16'($urandom_range(45)); end
      else if (r < 11) begin busWe = 1; busAddr = 4'd2; busWdata = 16'($urandom_range(3)); end
      else if (r < 13) begin busWe = 1; busAddr = 4'd3; busWdata = 16'($urandom_range(6)); end
      else if (r < 14) begin busWe = 1; busAddr = 4'd0; busWdata = {14'd0, 1'($urandom_range(1)), 1'b1}; end
      else if (r < 15 && $urandom_range(3) == 0) begin busWe = 1; busAddr = 4'd0; busWdata = 16'd0; end
      else if (r < 18) brakeIn = ($urandom_range(4) == 0) ? 1'b1 : 1'b0;
      else if (r < 21) begin busWe = 1; busAddr = 4'd9; busWdata = 16'($urandom_range(3)); end
      else if (r < 22) begin busWe = 1; busAddr = 4'd8; busWdata = 16'($urandom_range(255)); end
      @(posedge clk); #1;
      if (brakeIn && $urandom_range(3) == 0) brakeIn = 1'b0;
    end
    busWe = 1'b0; brakeIn = 1'b0;
    cyc(5);
    done = 1'b1;
    summary();
  end
endmodule